// File: doc/BRIEF.md
# Accumulator Stored-Program Machine

This block is a small stored-program processor whose program and data share a single word memory. It holds a 16-bit accumulator and an instruction counter. Every instruction takes two consecutive words: an opcode word, then a parameter word that is either a constant or a memory address. The instruction set has no indirect addressing. A program gets that effect by storing the accumulator into the parameter word of one of its own instructions, which rewrites its own code.

A host fills the memory through a preload port while `pre_en` is high. The machine does not advance while `pre_en` is high. Once `pre_en` falls, execution starts at word 0. Input values arrive on a ready/valid stream and printed values leave on another ready/valid stream. A halted flag reports that execution has stopped. A separate fault flag tells an addressing error apart from an ordinary stop.

Top module: `asm_machine`

## Requirements
- R1: Reset clears the instruction counter to 0, the accumulator and every memory word to 0, and drives `halted`, `fault`, `out_valid` and `in_ready` low.
- R2: Opcode 1 places the 16-bit parameter word itself into the accumulator.
- R3: Opcode 2 adds, and opcode 3 subtracts, the word at the parameter address to or from the accumulator, with 16-bit two's complement wraparound.
- R4: Opcode 4 writes the accumulator to the parameter address. When that address is a word of the program, later fetches of that word return the new value.
- R5: Opcode 5 sets the instruction counter to the parameter when the accumulator, read as signed, is strictly greater than zero. A zero or negative accumulator continues with the next instruction.
- R6: Opcode 6 raises `in_ready` and waits with the counter unchanged until `in_valid` is high. It then writes `in_data` to the parameter address. `in_ready` and `out_valid` are never high together.
- R7: Opcode 7 raises `out_valid` with `out_data` equal to the word at the parameter address. Both stay unchanged until `out_ready` is high.
- R8: Any opcode word other than 1 through 7, including 0 and negative values, halts the machine with `fault` low. `halted` then stays high until reset.
- R9: Opcodes 2, 3, 4, 6 and 7 with a parameter address of at least DEPTH halt the machine with `fault` high.
- R10: Fetching an instruction whose second word would lie at or beyond DEPTH halts the machine with `fault` high.
- R11: While `pre_en` is high, the word `pre_data` is written at `pre_addr` on each clock, the machine does not advance, and `in_ready` and `out_valid` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_en | input | 1 | Preload enable; pauses execution |
| pre_addr | input | $clog2(DEPTH) | Preload word address |
| pre_data | input | 16 | Preload word value |
| in_valid | input | 1 | Input stream valid |
| in_ready | output | 1 | Machine waits for an input word |
| in_data | input | 16 | Input stream word |
| out_valid | output | 1 | Printed word available |
| out_ready | input | 1 | Consumer accepts printed word |
| out_data | output | 16 | Printed word |
| halted | output | 1 | Execution has stopped |
| fault | output | 1 | Stop was caused by an address error |

## Verification
Two events can land on the same clock edge. The input handshake and the memory write it causes happen in the one execute cycle. A stream stall and the instruction counter also interact: the counter must hold for exactly as long as the handshake is withheld. The bench provokes a long input stall followed by a value that drives a counting loop, and it holds `out_ready` low across a print. A scoreboard pairs each accepted output with the value computed from the program. Loss, duplication or reordering of printed words, or data that changes during a stall, shows up as a mismatch.

// File: rtl/asm_pkg.sv
package asm_pkg;
    localparam int DATA_W = 16;

    localparam logic [DATA_W-1:0] OP_LDC = 16'd1;
    localparam logic [DATA_W-1:0] OP_ADD = 16'd2;
    localparam logic [DATA_W-1:0] OP_SUB = 16'd3;
    localparam logic [DATA_W-1:0] OP_STO = 16'd4;
    localparam logic [DATA_W-1:0] OP_BPOS = 16'd5;
    localparam logic [DATA_W-1:0] OP_IN  = 16'd6;
    localparam logic [DATA_W-1:0] OP_OUT = 16'd7;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_EXEC  = 2'd1,
        PH_HALT  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e            phase;
        logic [DATA_W-1:0] ic;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] op;
        logic [DATA_W-1:0] par;
        logic              fault;
    } core_state_t;
endpackage

// File: rtl/asm_store.sv
module asm_store #(
    parameter int DEPTH = 64,
    parameter int W     = 16,
    parameter int NRD   = 3,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [W-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0] raddr,
    output logic [NRD-1:0][W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem_q[raddr[g]];
    end
endmodule

// File: rtl/asm_range.sv
module asm_range #(
    parameter int W     = 16,
    parameter int LIMIT = 64,
    parameter int AW    = 6
) (
    input  logic [W-1:0]  addr,
    output logic          ok,
    output logic [AW-1:0] idx
);
    localparam logic [W-1:0] LIM_W = W'(LIMIT);

    assign ok  = addr < LIM_W;
    assign idx = addr[AW-1:0];
endmodule

// File: rtl/asm_alu.sv
module asm_alu #(
    parameter int W = 16
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] operand,
    output logic [W-1:0] sum,
    output logic [W-1:0] diff,
    output logic         positive
);
    assign sum      = acc + operand;
    assign diff     = acc - operand;
    assign positive = !acc[W-1] && (|acc);
endmodule

// File: rtl/asm_machine.sv
module asm_machine
    import asm_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_en,
    input  logic [AW-1:0]     pre_addr,
    input  logic [DATA_W-1:0] pre_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              halted,
    output logic              fault
);
    localparam int NRD = 3;

    core_state_t st_q, st_d;

    logic                     fetch_ok, par_ok;
    logic [AW-1:0]            fetch_idx, par_idx;
    logic [NRD-1:0][AW-1:0]   rd_addr;
    logic [NRD-1:0][DATA_W-1:0] rd_data;
    logic                     ex_we, mem_we;
    logic [AW-1:0]            mem_waddr;
    logic [DATA_W-1:0]        ex_wdata, mem_wdata;
    logic [DATA_W-1:0]        alu_sum, alu_diff;
    logic                     acc_pos;
    logic                     in_rdy_d, out_vld_d;

    asm_range #(.W(DATA_W), .LIMIT(DEPTH - 1), .AW(AW)) u_fetch_rng (
        .addr (st_q.ic),
        .ok   (fetch_ok),
        .idx  (fetch_idx)
    );

    asm_range #(.W(DATA_W), .LIMIT(DEPTH), .AW(AW)) u_par_rng (
        .addr (st_q.par),
        .ok   (par_ok),
        .idx  (par_idx)
    );

    assign rd_addr[0] = fetch_idx;
    assign rd_addr[1] = fetch_idx + AW'(1);
    assign rd_addr[2] = par_idx;

    assign mem_we    = pre_en ? 1'b1 : ex_we;
    assign mem_waddr = pre_en ? pre_addr : par_idx;
    assign mem_wdata = pre_en ? pre_data : ex_wdata;

    asm_store #(.DEPTH(DEPTH), .W(DATA_W), .NRD(NRD)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    asm_alu #(.W(DATA_W)) u_alu (
        .acc      (st_q.acc),
        .operand  (rd_data[2]),
        .sum      (alu_sum),
        .diff     (alu_diff),
        .positive (acc_pos)
    );

    always_comb begin
        st_d      = st_q;
        ex_we     = 1'b0;
        ex_wdata  = st_q.acc;
        in_rdy_d  = 1'b0;
        out_vld_d = 1'b0;

        if (!pre_en) begin
            unique case (st_q.phase)
                PH_FETCH: begin
                    if (!fetch_ok) begin
                        st_d.phase = PH_HALT;
                        st_d.fault = 1'b1;
                    end else begin
                        st_d.op    = rd_data[0];
                        st_d.par   = rd_data[1];
                        st_d.phase = PH_EXEC;
                    end
                end
                PH_EXEC: begin
                    st_d.phase = PH_FETCH;
                    st_d.ic    = st_q.ic + DATA_W'(2);
                    case (st_q.op)
                        OP_LDC: st_d.acc = st_q.par;
                        OP_BPOS: begin
                            if (acc_pos) st_d.ic = st_q.par;
                        end
                        OP_ADD, OP_SUB, OP_STO, OP_IN, OP_OUT: begin
                            if (!par_ok) begin
                                st_d.phase = PH_HALT;
                                st_d.fault = 1'b1;
                                st_d.ic    = st_q.ic;
                            end else if (st_q.op == OP_ADD) begin
                                st_d.acc = alu_sum;
                            end else if (st_q.op == OP_SUB) begin
                                st_d.acc = alu_diff;
                            end else if (st_q.op == OP_STO) begin
                                ex_we = 1'b1;
                            end else if (st_q.op == OP_IN) begin
                                in_rdy_d = 1'b1;
                                if (in_valid) begin
                                    ex_we    = 1'b1;
                                    ex_wdata = in_data;
                                end else begin
                                    st_d.phase = PH_EXEC;
                                    st_d.ic    = st_q.ic;
                                end
                            end else begin
                                out_vld_d = 1'b1;
                                if (!out_ready) begin
                                    st_d.phase = PH_EXEC;
                                    st_d.ic    = st_q.ic;
                                end
                            end
                        end
                        default: begin
                            st_d.phase = PH_HALT;
                            st_d.ic    = st_q.ic;
                        end
                    endcase
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_FETCH, ic: '0, acc: '0, op: '0, par: '0, fault: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = in_rdy_d;
    assign out_valid = out_vld_d;
    assign out_data  = rd_data[2];
    assign halted    = (st_q.phase == PH_HALT);
    assign fault     = st_q.fault;
endmodule

// File: rtl/asm_machine_chk.sv
module asm_machine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pre_en,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [15:0] out_data,
    input logic        halted,
    input logic        fault
);
    // R6
    in_wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid && !pre_en) |=> in_ready);

    // R6
    one_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !pre_en) |=> (out_valid && $stable(out_data)));

    // R8
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R9
    fault_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> halted);

    // R11
    preload_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en |-> (!in_ready && !out_valid));
endmodule

bind asm_machine asm_machine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pre_en    (pre_en),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .halted    (halted),
    .fault     (fault)
);

// File: tb/sim_asm_machine.sv
module sim_asm_machine;
    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pre_en = 1'b1;
    logic [AW-1:0] pre_addr = '0;
    logic [15:0]   pre_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [15:0]   in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [15:0]   out_data;
    logic          halted;
    logic          fault;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    asm_machine #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .pre_en(pre_en), .pre_addr(pre_addr),
        .pre_data(pre_data), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .halted(halted), .fault(fault)
    );

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_out(logic [15:0] v, string req);
        exp_q.push_back(v);
        tag_q.push_back(req);
    endtask

    // scoreboard monitor: a handshake seen here completes at the next edge
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected output", {16'h0, out_data}, 32'hFFFF_FFFF);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(out_data == e, t, {16'h0, out_data}, {16'h0, e});
            end
        end
    end

    task automatic do_reset();
        pre_en = 1'b1;
        in_valid = 1'b0;
        out_ready = 1'b1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
    endtask

    task automatic poke(int a, logic [15:0] v);
        pre_addr = AW'(a);
        pre_data = v;
        @(posedge clk);
        #2;
    endtask

    task automatic put(int a, logic [15:0] op, logic [15:0] par);
        poke(a, op);
        poke(a + 1, par);
    endtask

    task automatic launch();
        pre_en = 1'b0;
    endtask

    task automatic wait_halt(int lim, string req);
        int k = 0;
        @(negedge clk);
        while (!halted && k < lim) begin
            @(negedge clk);
            k++;
        end
        check(halted == 1'b1, req, {31'h0, halted}, 32'h1);
    endtask

    task automatic feed(logic [15:0] v);
        @(posedge clk);
        #2;
        in_valid = 1'b1;
        in_data = v;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #2 in_valid = 1'b0;
    endtask

    task automatic queue_empty(string req);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: values right after reset
        do_reset();
        #1;
        check(!halted && !fault, "R1 flags after reset", {halted, fault}, 0);
        check(!out_valid && !in_ready, "R1 streams after reset", {out_valid, in_ready}, 0);

        // Program A: R2, R3, R7, R8 with output backpressure
        put(0, 16'd1, 16'd5);
        put(2, 16'd2, 16'd40);
        put(4, 16'd4, 16'd41);
        put(6, 16'd7, 16'd41);
        put(8, 16'd3, 16'd42);
        put(10, 16'd4, 16'd41);
        put(12, 16'd7, 16'd41);
        put(14, 16'd1, 16'h7FFF);
        put(16, 16'd2, 16'd43);
        put(18, 16'd4, 16'd41);
        put(20, 16'd7, 16'd41);
        put(22, 16'd0, 16'd0);
        poke(40, 16'd7);
        poke(42, 16'd20);
        poke(43, 16'd1);
        out_ready = 1'b0;
        expect_out(16'd12, "R2 R3 add result");
        expect_out(16'hFFF8, "R3 subtract to negative");
        expect_out(16'h8000, "R3 wraparound");
        launch();
        begin
            logic [15:0] held;
            @(negedge clk);
            while (!out_valid) @(negedge clk);
            held = out_data;
            repeat (5) @(negedge clk);
            check(out_valid == 1'b1, "R7 valid held in stall", {31'h0, out_valid}, 1);
            check(out_data == held, "R7 data held in stall", {16'h0, out_data}, {16'h0, held});
            check(!halted, "R7 no progress in stall", {31'h0, halted}, 0);
        end
        @(posedge clk);
        #2 out_ready = 1'b1;
        wait_halt(200, "R8 opcode 0 halts");
        check(fault == 1'b0, "R8 no fault on opcode 0", {31'h0, fault}, 0);
        repeat (3) @(negedge clk);
        check(halted == 1'b1, "R8 halt sticky", {31'h0, halted}, 1);
        queue_empty("R7 all outputs seen A");

        // R1: reset leaves the halted state
        do_reset();
        #1;
        check(!halted, "R1 reset clears halt", {31'h0, halted}, 0);

        // Program B: R5, R6, R11 countdown loop
        put(0, 16'd6, 16'd50);
        put(2, 16'd1, 16'd0);
        put(4, 16'd2, 16'd50);
        put(6, 16'd5, 16'd10);
        put(8, 16'd0, 16'd0);
        put(10, 16'd4, 16'd50);
        put(12, 16'd7, 16'd50);
        put(14, 16'd3, 16'd51);
        put(16, 16'd5, 16'd10);
        put(18, 16'd0, 16'd0);
        poke(51, 16'd1);
        repeat (4) @(negedge clk);
        check(!in_ready && !out_valid && !halted, "R11 paused in preload",
              {in_ready, out_valid, halted}, 0);
        launch();
        repeat (10) @(negedge clk);
        check(in_ready == 1'b1, "R6 waits for input", {31'h0, in_ready}, 1);
        check(!out_valid && !halted, "R6 no progress while waiting", {out_valid, halted}, 0);
        expect_out(16'd3, "R5 loop 3");
        expect_out(16'd2, "R5 loop 2");
        expect_out(16'd1, "R5 loop 1");
        feed(16'd3);
        wait_halt(300, "R5 loop ends");
        check(!fault, "R5 no fault", {31'h0, fault}, 0);
        queue_empty("R5 all outputs seen");

        // Program B again, negative input: branch not taken
        do_reset();
        put(0, 16'd6, 16'd50);
        put(2, 16'd1, 16'd0);
        put(4, 16'd2, 16'd50);
        put(6, 16'd5, 16'd10);
        put(8, 16'd0, 16'd0);
        put(10, 16'd7, 16'd50);
        launch();
        feed(16'hFFFE);
        wait_halt(100, "R5 negative falls through");
        queue_empty("R5 negative prints nothing");

        // zero input: branch not taken
        do_reset();
        put(0, 16'd6, 16'd50);
        put(2, 16'd1, 16'd0);
        put(4, 16'd2, 16'd50);
        put(6, 16'd5, 16'd10);
        put(8, 16'd0, 16'd0);
        put(10, 16'd7, 16'd50);
        launch();
        feed(16'd0);
        wait_halt(100, "R5 zero falls through");
        queue_empty("R5 zero prints nothing");

        // Program C: R4 self-modifying print operand, R8 opcode 8
        do_reset();
        put(0, 16'd1, 16'd45);
        put(2, 16'd4, 16'd7);
        put(4, 16'd1, 16'd0);
        put(6, 16'd7, 16'd44);
        put(8, 16'd8, 16'd0);
        poke(44, 16'd111);
        poke(45, 16'd222);
        expect_out(16'd222, "R4 rewritten operand");
        launch();
        wait_halt(100, "R8 opcode 8 halts");
        check(!fault, "R8 opcode 8 no fault", {31'h0, fault}, 0);
        queue_empty("R4 output seen");

        // negative opcode halts
        do_reset();
        put(0, 16'hFFFF, 16'd0);
        launch();
        wait_halt(20, "R8 negative opcode halts");
        check(!fault, "R8 negative opcode no fault", {31'h0, fault}, 0);

        // Program D: R9 out-of-range data address
        do_reset();
        put(0, 16'd2, 16'd64);
        repeat (3) @(negedge clk);
        check(!halted && !fault, "R11 no execution in preload", {halted, fault}, 0);
        launch();
        wait_halt(20, "R9 bad address halts");
        check(fault == 1'b1, "R9 fault set", {31'h0, fault}, 1);

        // Program E: R10 fetch past the end
        do_reset();
        put(0, 16'd1, 16'd1);
        put(2, 16'd5, 16'd63);
        launch();
        wait_halt(20, "R10 fetch past end halts");
        check(fault == 1'b1, "R10 fault set", {31'h0, fault}, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule